// File: doc/BRIEF.md
# Stimulator Command Frame Receiver

The receiver takes one serial line from the carrier detector of an inductively powered stimulator: 1 means carrier present, 0 means carrier absent. It recovers fixed-length command frames from the keyed carrier and runs on the system clock. Each bit lasts `CLKS_PER_BIT` clocks and is sampled once, at the middle of the bit. The line first passes through a synchronizer.

A frame has these parts, in order:
- a start pair: a 0 bit and then a 1 bit;
- three command bytes: electrode channel, pulse amplitude, pulse duration;
- a CRC byte.

The start pair is accepted only after the line has been idle high for a set time. The receiver shifts the three bytes in and runs all 32 bits through a CRC-8 register. A frame whose residue is zero is accepted. Its three fields appear on the outputs together with a one-cycle strobe. Any other frame is dropped, and only a one-cycle error pulse marks it. The link is one-way, so the receiver never answers, repairs or retries a frame.

The controller is a five-state machine:
- `ST_IDLE` waits for the idle condition and a falling edge.
- `ST_START_LO` checks the first start bit.
- `ST_START_HI` checks the second start bit.
- `ST_FIELDS` takes in the 24 command bits.
- `ST_CHECK` takes in the 8 CRC bits.

Its transitions are:
- idle-then-edge: `ST_IDLE`→`ST_START_LO`
- low-bit-confirmed: `ST_START_LO`→`ST_START_HI`
- false-start abort: `ST_START_LO`→`ST_IDLE`
- high-bit-confirmed: `ST_START_HI`→`ST_FIELDS`
- bad-start abort: `ST_START_HI`→`ST_IDLE`
- last-field-bit: `ST_FIELDS`→`ST_CHECK`
- frame-complete: `ST_CHECK`→`ST_IDLE`

Top module: `stim_cmd_rx`

## Requirements
- R1: A synchronous active-low reset drives `cmd_valid`, `crc_err` and all three field outputs to zero and discards any partly received frame.
- R2: A bit lasts CLKS_PER_BIT (10) clocks. Only the synchronized line value 5 clocks after the bit's start is used, so distortion in the first 4 clocks of a bit has no effect.
- R3: The start pair must read 0 then 1. If the first bit samples as 1 or the second samples as 0, the frame is abandoned with no output pulse.
- R4: After the start pair come the channel, amplitude and duration bytes, then the CRC byte. Each byte is sent most significant bit first.
- R5: The CRC is CRC-8 with polynomial 0x07 (x^8+x^2+x+1), initial value 0 and no final inversion, taken over the 24 field bits. On a match, `cmd_valid` is high for exactly one cycle, and the three fields update in the same cycle.
- R6: On a mismatch, `crc_err` is high for exactly one cycle, `cmd_valid` stays low and the fields keep their values.
- R7: The strobe (`cmd_valid` or `crc_err`) rises on the 337th clock edge after the first edge at which `rx_din` shows the low start bit (counting that edge as the 0th). This is 2 synchronizer clocks, 33 full bits and half a bit, with the strobe registered on that edge.
- R8: A falling edge counts as a frame start only after IDLE_BITS×CLKS_PER_BIT (20) consecutive synchronized high clocks. A frame sent after a shorter high gap is ignored completely.
- R9: `cmd_valid` and `crc_err` are never high together, and neither is high two cycles in a row.
- R10: Between accepted frames the field outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_din | input | 1 | Demodulated carrier-present line (1 = carrier) |
| cmd_valid | output | 1 | One-cycle strobe for an accepted frame |
| crc_err | output | 1 | One-cycle strobe for a frame dropped on CRC |
| cmd_channel | output | 8 | Electrode channel of the last accepted frame |
| cmd_amplitude | output | 8 | Amplitude code of the last accepted frame |
| cmd_duration | output | 8 | Duration code of the last accepted frame |

## Verification
The main path is driven with several kinds of frame:
- Clean frames with mixed bytes, all-zero bytes and all-one bytes. These confirm field order, bit order and the exact strobe cycle.
- Frames with a corrupted CRC byte and frames with a flipped field bit. These separate the acceptance path from the rejection path and show that the fields hold.
- A frame whose bit edges arrive four clocks late. This shows that only the mid-bit sample matters.

A short low glitch, a start pair held low for two bits, and a frame sent after too short an idle gap must all leave the outputs untouched. A reset in mid-frame followed by a clean frame shows that no partial state survives.

// File: rtl/stim_rx_pkg.sv
package stim_rx_pkg;

    localparam int FIELD_W    = 8;
    localparam int NUM_FIELDS = 3;
    localparam int PAYLOAD_W  = FIELD_W * NUM_FIELDS;
    localparam int CRC_W      = 8;
    localparam logic [CRC_W-1:0] CRC_POLY = 8'h07;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START_LO,
        ST_START_HI,
        ST_FIELDS,
        ST_CHECK
    } rx_state_t;

    // first byte on the wire lands in the most significant slot
    typedef struct packed {
        logic [FIELD_W-1:0] channel;
        logic [FIELD_W-1:0] amplitude;
        logic [FIELD_W-1:0] duration;
    } stim_cmd_t;

endpackage

// File: rtl/stim_rx_sync.sv
module stim_rx_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= RST_VAL;
                else        chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= {STAGES{RST_VAL}};
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/stim_rx_bittimer.sv
module stim_rx_bittimer #(
    parameter int CLKS_PER_BIT = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic run,
    output logic sample_tick,
    output logic last_tick
);

    localparam int CW = $clog2(CLKS_PER_BIT);
    localparam logic [CW-1:0] C_ONE  = CW'(1);
    localparam logic [CW-1:0] C_MID  = CW'(CLKS_PER_BIT / 2);
    localparam logic [CW-1:0] C_LAST = CW'(CLKS_PER_BIT - 1);

    logic [CW-1:0] cnt;

    // the edge cycle is position 0, so a restart loads position 1
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt <= '0;
        else if (restart) cnt <= C_ONE;
        else if (run)     cnt <= (cnt == C_LAST) ? '0 : cnt + C_ONE;
        else              cnt <= '0;
    end

    assign sample_tick = run && (cnt == C_MID);
    assign last_tick   = run && (cnt == C_LAST);

endmodule

// File: rtl/stim_rx_crc8.sv
module stim_rx_crc8 #(
    parameter int           W    = 8,
    parameter logic [W-1:0] POLY = 8'h07
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic shift_en,
    input  logic bit_in,
    output logic next_zero
);

    logic [W-1:0] crc_q;
    logic [W-1:0] crc_nxt;

    // one serial division step, message bit entering at the top
    always_comb begin
        crc_nxt = {crc_q[W-2:0], 1'b0};
        if (crc_q[W-1] ^ bit_in) crc_nxt = crc_nxt ^ POLY;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear) crc_q <= '0;
        else if (shift_en)   crc_q <= crc_nxt;
    end

    assign next_zero = (crc_nxt == '0);

endmodule

// File: rtl/stim_rx_shifter.sv
module stim_rx_shifter #(
    parameter int WIDTH = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             bit_in,
    output logic [WIDTH-1:0] data
);

    always_ff @(posedge clk) begin
        if (!rst_n)        data <= '0;
        else if (shift_en) data <= {data[WIDTH-2:0], bit_in};
    end

endmodule

// File: rtl/stim_cmd_rx.sv
module stim_cmd_rx
    import stim_rx_pkg::*;
#(
    parameter int CLKS_PER_BIT = 10,
    parameter int IDLE_BITS    = 2,
    parameter int SYNC_STAGES  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rx_din,
    output logic               cmd_valid,
    output logic               crc_err,
    output logic [FIELD_W-1:0] cmd_channel,
    output logic [FIELD_W-1:0] cmd_amplitude,
    output logic [FIELD_W-1:0] cmd_duration
);

    localparam int IDLE_CYCLES = IDLE_BITS * CLKS_PER_BIT;
    localparam int IW          = $clog2(IDLE_CYCLES + 1);
    localparam int BW          = $clog2(PAYLOAD_W);
    localparam logic [IW-1:0] IDLE_MAX     = IW'(IDLE_CYCLES);
    localparam logic [BW-1:0] PAYLOAD_LAST = BW'(PAYLOAD_W - 1);
    localparam logic [BW-1:0] CRC_LAST     = BW'(CRC_W - 1);

    rx_state_t              state_q, state_d;
    logic                   line;
    logic [IW-1:0]          idle_cnt;
    logic                   idle_ok;
    logic [BW-1:0]          bit_idx;
    logic                   restart, run, sample_tick, last_tick;
    logic                   crc_clear, crc_shift, pay_shift, frame_done;
    logic                   next_zero;
    logic [PAYLOAD_W-1:0]   payload;
    stim_cmd_t              cmd_q;

    stim_rx_sync #(
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b0)
    ) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (rx_din),
        .q     (line)
    );

    assign run = (state_q != ST_IDLE);

    stim_rx_bittimer #(
        .CLKS_PER_BIT (CLKS_PER_BIT)
    ) i_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .restart     (restart),
        .run         (run),
        .sample_tick (sample_tick),
        .last_tick   (last_tick)
    );

    stim_rx_crc8 #(
        .W    (CRC_W),
        .POLY (CRC_POLY)
    ) i_crc (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (crc_clear),
        .shift_en  (crc_shift),
        .bit_in    (line),
        .next_zero (next_zero)
    );

    stim_rx_shifter #(
        .WIDTH (PAYLOAD_W)
    ) i_payload (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (pay_shift),
        .bit_in   (line),
        .data     (payload)
    );

    // run of high samples seen while waiting; saturates at the threshold
    always_ff @(posedge clk) begin
        if (!rst_n || state_q != ST_IDLE) idle_cnt <= '0;
        else if (!line)                   idle_cnt <= '0;
        else if (idle_cnt != IDLE_MAX)    idle_cnt <= idle_cnt + IW'(1);
    end

    assign idle_ok = (idle_cnt == IDLE_MAX);

    // position inside the payload or the check byte
    always_ff @(posedge clk) begin
        if (!rst_n || state_d != state_q) bit_idx <= '0;
        else if (pay_shift || crc_shift)  bit_idx <= bit_idx + BW'(1);
    end

    // next-state and datapath controls
    always_comb begin
        state_d    = state_q;
        restart    = 1'b0;
        crc_clear  = 1'b0;
        crc_shift  = 1'b0;
        pay_shift  = 1'b0;
        frame_done = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                crc_clear = 1'b1;
                if (!line && idle_ok) begin
                    restart = 1'b1;
                    state_d = ST_START_LO;
                end
            end
            ST_START_LO: begin
                if (sample_tick && line) state_d = ST_IDLE;
                else if (last_tick)      state_d = ST_START_HI;
            end
            ST_START_HI: begin
                if (sample_tick && !line) state_d = ST_IDLE;
                else if (last_tick)       state_d = ST_FIELDS;
            end
            ST_FIELDS: begin
                if (sample_tick) begin
                    crc_shift = 1'b1;
                    pay_shift = 1'b1;
                    if (bit_idx == PAYLOAD_LAST) state_d = ST_CHECK;
                end
            end
            ST_CHECK: begin
                if (sample_tick) begin
                    crc_shift = 1'b1;
                    if (bit_idx == CRC_LAST) begin
                        frame_done = 1'b1;
                        state_d    = ST_IDLE;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // output register: strobes and the held command
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_valid <= 1'b0;
            crc_err   <= 1'b0;
            cmd_q     <= '0;
        end else begin
            cmd_valid <= frame_done && next_zero;
            crc_err   <= frame_done && !next_zero;
            if (frame_done && next_zero) cmd_q <= stim_cmd_t'(payload);
        end
    end

    assign cmd_channel   = cmd_q.channel;
    assign cmd_amplitude = cmd_q.amplitude;
    assign cmd_duration  = cmd_q.duration;

endmodule

// File: rtl/stim_cmd_rx_chk.sv
module stim_cmd_rx_chk
    import stim_rx_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               cmd_valid,
    input logic               crc_err,
    input logic [FIELD_W-1:0] cmd_channel,
    input logic [FIELD_W-1:0] cmd_amplitude,
    input logic [FIELD_W-1:0] cmd_duration,
    input rx_state_t          state
);

    assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid && crc_err));

    assert_valid_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    assert_err_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        crc_err |=> !crc_err);

    assert_fields_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_valid && $past(rst_n)) |->
            $stable({cmd_channel, cmd_amplitude, cmd_duration}));

    assert_strobe_after_check_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid || crc_err) |-> ($past(state) == ST_CHECK));

    assert_strobe_back_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid || crc_err) |-> (state == ST_IDLE));

    assert_start_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_START_HI) |->
            ($past(state) == ST_START_LO || $past(state) == ST_START_HI));

    assert_fields_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FIELDS && $past(state) != ST_FIELDS) |->
            ($past(state) == ST_START_HI));

endmodule

bind stim_cmd_rx stim_cmd_rx_chk i_stim_cmd_rx_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_valid     (cmd_valid),
    .crc_err       (crc_err),
    .cmd_channel   (cmd_channel),
    .cmd_amplitude (cmd_amplitude),
    .cmd_duration  (cmd_duration),
    .state         (state_q)
);

// File: tb/test_stim_cmd_rx.sv
`timescale 1ns/1ps
module test_stim_cmd_rx;

    localparam int CLKS = 10;
    localparam int SYNC = 2;
    // drive cycle of the low start bit to strobe cycle (R7)
    localparam int LAT  = SYNC + 33 * CLKS + CLKS / 2 + 1;
    localparam int WD   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       din = 1'b1;
    logic       cmd_valid, crc_err;
    logic [7:0] cmd_channel, cmd_amplitude, cmd_duration;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    typedef struct {
        int       cyc;
        bit       good;
        logic [7:0] ch, am, du;
    } ev_t;

    ev_t evq[$];
    logic [7:0] exp_ch = 8'h0, exp_am = 8'h0, exp_du = 8'h0;

    always #5 clk = ~clk;

    stim_cmd_rx #(.CLKS_PER_BIT(CLKS), .IDLE_BITS(2), .SYNC_STAGES(SYNC)) i_stim_cmd_rx (
        .clk           (clk),
        .rst_n         (rst_n),
        .rx_din        (din),
        .cmd_valid     (cmd_valid),
        .crc_err       (crc_err),
        .cmd_channel   (cmd_channel),
        .cmd_amplitude (cmd_amplitude),
        .cmd_duration  (cmd_duration)
    );

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // reference model, compared once per clock just after the edge
    always @(posedge clk) begin
        logic ev_v, ev_e;
        #1;
        ev_v = 1'b0;
        ev_e = 1'b0;
        if (!rst_n) begin
            evq.delete();
            exp_ch = 8'h0; exp_am = 8'h0; exp_du = 8'h0;
        end else if (evq.size() > 0 && evq[0].cyc == cyc) begin
            ev_t e;
            e = evq.pop_front();
            if (e.good) begin
                ev_v = 1'b1;
                exp_ch = e.ch; exp_am = e.am; exp_du = e.du;
            end else begin
                ev_e = 1'b1;
            end
        end
        chk("R5 R7 cmd_valid", cmd_valid, ev_v);
        chk("R6 crc_err", crc_err, ev_e);
        chk("R9 strobes exclusive", cmd_valid & crc_err, 0);
        chk("R4 R10 channel", cmd_channel, exp_ch);
        chk("R4 R10 amplitude", cmd_amplitude, exp_am);
        chk("R4 R10 duration", cmd_duration, exp_du);
    end

    function automatic logic [7:0] calc_crc(input logic [23:0] p);
        logic [7:0] c;
        c = 8'h00;
        for (int i = 23; i >= 0; i--) begin
            logic fb;
            fb = c[7] ^ p[i];
            c  = {c[6:0], 1'b0};
            if (fb) c = c ^ 8'h07;
        end
        return c;
    endfunction

    task automatic idle_line(input int n);
        repeat (n) begin @(negedge clk); din = 1'b1; end
    endtask

    task automatic low_line(input int n);
        repeat (n) begin @(negedge clk); din = 1'b0; end
    endtask

    // skew: clocks at the start of each bit (after the first) that still
    // carry the previous bit's value; stop_after cuts the frame short
    task automatic send_frame(input logic [7:0] ch, input logic [7:0] am,
                              input logic [7:0] du, input logic [7:0] crc_flip,
                              input logic [7:0] ch_flip, input int skew,
                              input int stop_after, input bit expect_out);
        logic [33:0] bits;
        logic [7:0]  crc;
        crc  = calc_crc({ch, am, du}) ^ crc_flip;
        bits = {2'b01, ch ^ ch_flip, am, du, crc};
        for (int b = 0; b < 34; b++) begin
            for (int k = 0; k < CLKS; k++) begin
                if (b * CLKS + k >= stop_after) return;
                @(negedge clk);
                din = (b > 0 && k < skew) ? bits[34-b] : bits[33-b];
                if (b == 0 && k == 0 && expect_out) begin
                    ev_t e;
                    e.cyc  = cyc + LAT;
                    e.good = (crc_flip == 8'h0) && (ch_flip == 8'h0);
                    e.ch = ch; e.am = am; e.du = du;
                    evq.push_back(e);
                end
            end
        end
    endtask

    task automatic finish_run;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (WD) @(posedge clk);
        bad++;
        $display("FAIL R7 watchdog: got still running expected finished");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (4) @(negedge clk);
        @(posedge clk); #2;
        chk("R1 reset valid", cmd_valid, 0);
        chk("R1 reset err", crc_err, 0);
        chk("R1 reset fields", {cmd_channel, cmd_amplitude, cmd_duration}, 0);
        @(negedge clk); rst_n = 1'b1;

        // R8: too short an idle after reset, frame must be ignored
        idle_line(8);
        send_frame(8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 0, 1000, 1'b0);
        idle_line(30);

        // R4 R5: clean frames, mixed bytes
        send_frame(8'h03, 8'h80, 8'hFF, 8'h00, 8'h00, 0, 1000, 1'b1);
        idle_line(25);
        send_frame(8'hA5, 8'h5A, 8'h01, 8'h00, 8'h00, 0, 1000, 1'b1);
        idle_line(25);

        // R6: corrupted check byte, then a flipped field bit
        send_frame(8'h11, 8'h22, 8'h33, 8'h01, 8'h00, 0, 1000, 1'b1);
        idle_line(25);
        send_frame(8'h44, 8'h55, 8'h66, 8'h00, 8'h80, 0, 1000, 1'b1);
        idle_line(25);

        // R3: short low glitch, then a start pair held low for two bits
        low_line(3);
        idle_line(30);
        low_line(2 * CLKS);
        idle_line(30);

        // R2: bit edges four clocks late are still read correctly
        send_frame(8'hC3, 8'h3C, 8'h96, 8'h00, 8'h00, 4, 1000, 1'b1);
        idle_line(25);

        // R5 boundaries: all-zero and all-one commands
        send_frame(8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 0, 1000, 1'b1);
        idle_line(25);
        send_frame(8'hFF, 8'hFF, 8'hFF, 8'h00, 8'h00, 0, 1000, 1'b1);
        idle_line(25);

        // R1: reset in mid-frame drops the partial frame and clears fields
        send_frame(8'h7E, 8'h81, 8'h42, 8'h00, 8'h00, 0, 150, 1'b0);
        @(negedge clk); rst_n = 1'b0; din = 1'b1;
        repeat (2) @(negedge clk);
        @(posedge clk); #2;
        chk("R1 mid-frame reset fields", {cmd_channel, cmd_amplitude, cmd_duration}, 0);
        @(negedge clk); rst_n = 1'b1;
        idle_line(30);
        send_frame(8'h09, 8'h10, 8'hC8, 8'h00, 8'h00, 0, 1000, 1'b1);
        idle_line(30);

        chk("R5 no outstanding strobe", evq.size(), 0);
        finish_run();
    end

endmodule